// File: doc/BRIEF.md
# Stopwatch Time Counter

This block keeps the running time of a stopwatch. A free-running system clock (100 kHz in the target system) feeds a prescaler. The prescaler produces a one-cycle tick every `PRESCALE` clock cycles, which is a 100 Hz tick at the default setting. Each tick advances a chain of three two-digit BCD fields: hundredths of a second (00 to 99), seconds (00 to 59) and minutes (00 to `MIN_LAST`, 59 by default). A field carries into the next one when it wraps.

The surrounding logic controls the block with a run level and a synchronous clear. While run is low, both the time value and the prescaler phase freeze, so a resumed run finishes the partly counted tick. The block does nothing on its own: it counts while run is high and holds its value otherwise. It also drives a 1 Hz square wave for flashing an indicator. This wave is high during the second half of each second.

Top module: `stopwatch_timer`

## Requirements
- R1: While reset is asserted and after it is released, minutes, seconds and hundredths all read 00 and the blink output is 0.
- R2: While run is low and clear is low, the time value does not change and the prescaler phase is kept. After run returns high, the next tick comes once the run-high cycles before and after the pause add up to `PRESCALE`.
- R3: With run high, hundredths goes up by exactly one every `PRESCALE` clock cycles, and by nothing in between.
- R4: Hundredths counts 00 to 99 in BCD (high nibble tens, low nibble ones). On the tick that would pass 99, it returns to 00 and seconds goes up by one.
- R5: Seconds counts 00 to 59 in BCD. On the tick that would pass 59"99, seconds and hundredths return to 00 and minutes goes up by one.
- R6: Minutes counts 00 to `MIN_LAST` in BCD. The tick after `MIN_LAST`'59"99 returns every field to 00.
- R7: Clear high sets all fields to 00 on the next clock edge and restarts the prescaler phase. Clear wins over a tick that falls due in the same cycle.
- R8: Blink is high exactly while the tens digit of hundredths is 5 or more, which gives a 1 Hz square wave while running.
- R9: With the default `PRESCALE` of 1000, the first increment of hundredths comes on the 1000th run-high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Count enable level |
| clear | input | 1 | Synchronous return to 00'00"00 |
| minutes | output | 8 | Minutes, two BCD digits |
| seconds | output | 8 | Seconds, two BCD digits |
| hundredths | output | 8 | Hundredths of a second, two BCD digits |
| blink | output | 1 | 1 Hz indicator phase |

## Verification
The counter is driven with unbroken run stretches of different lengths, with a run stretch split by a pause that falls partway through a prescaler period, and with a clear that arrives on the very cycle a tick is due. The split run tells a prescaler that keeps its phase apart from one that restarts. The clear-on-tick case shows whether clear really wins over counting. The long runs end exactly at 49, 99, 59"99 and the last minute value, and then take one more tick. These separate each BCD digit rollover, the carry into each field and the blink edge. A second instance at the default prescale checks the exact 1000-cycle tick spacing.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef logic [7:0] bcd2_t;
  localparam int unsigned NUM_FIELDS = 3;
  localparam bcd2_t HUN_LAST_C = 8'h99;
  localparam bcd2_t SEC_LAST_C = 8'h59;
endpackage

// File: rtl/sw_rst_sync.sv
module sw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
  parameter int unsigned PRESCALE = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (run) begin
      if (at_last)    cnt_d = '0;
      else            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run & ~clr & at_last;

  // R2: phase is kept while stopped
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));
  // R7: clear restarts the phase
  p_phase_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  // R3: phase stays in range
  p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/sw_bcd_field.sv
module sw_bcd_field
  import sw_pkg::*;
#(
  parameter bcd2_t LAST = 8'h99
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  inc,
  output bcd2_t value,
  output logic  wrap
);
  logic [3:0] ones_q, ones_d, tens_q, tens_d;
  logic       at_last;

  assign value   = {tens_q, ones_q};
  assign at_last = (value == LAST);
  assign wrap    = inc & at_last;

  always_comb begin
    ones_d = ones_q;
    tens_d = tens_q;
    if (clr) begin
      ones_d = 4'd0;
      tens_d = 4'd0;
    end else if (inc) begin
      if (at_last) begin
        ones_d = 4'd0;
        tens_d = 4'd0;
      end else if (ones_q == 4'd9) begin
        ones_d = 4'd0;
        tens_d = tens_q + 4'd1;
      end else begin
        ones_d = ones_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= 4'd0;
      tens_q <= 4'd0;
    end else begin
      ones_q <= ones_d;
      tens_q <= tens_d;
    end
  end

  // R4 / R5 / R6: digits stay legal BCD and within the field limit
  p_digit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_q <= 4'd9) && (value <= LAST));
  // R4 / R5 / R6: a carry out leaves the field at 00
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (value == 8'h00));
  // R2: no increment, no clear, no change
  p_field_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(value));
  // R7: clear empties the field
  p_field_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (value == 8'h00));
endmodule

// File: rtl/stopwatch_timer.sv
module stopwatch_timer
  import sw_pkg::*;
#(
  parameter int unsigned PRESCALE = 1000,
  parameter logic [7:0]  MIN_LAST = 8'h59
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clear,
  output logic [7:0] minutes,
  output logic [7:0] seconds,
  output logic [7:0] hundredths,
  output logic       blink
);
  function automatic bcd2_t field_last(int unsigned idx);
    case (idx)
      0:       return HUN_LAST_C;
      1:       return SEC_LAST_C;
      default: return MIN_LAST;
    endcase
  endfunction

  logic  rst_sync_n;
  logic  carry [NUM_FIELDS+1];
  bcd2_t fval  [NUM_FIELDS];

  sw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sw_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .clr   (clear),
    .tick  (carry[0])
  );

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    sw_bcd_field #(.LAST(field_last(gi))) u_fld (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (clear),
      .inc   (carry[gi]),
      .value (fval[gi]),
      .wrap  (carry[gi+1])
    );
  end

  assign hundredths = fval[0];
  assign seconds    = fval[1];
  assign minutes    = fval[2];
  assign blink      = (fval[0][7:4] >= 4'd5);

  // R6: the last carry out returns every field to 00
  p_full_wrap_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    carry[NUM_FIELDS] |=> (minutes == 8'h00 && seconds == 8'h00 && hundredths == 8'h00));
  // R8: blink rises only as hundredths reaches 50
  p_blink_rise_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(blink) |-> (hundredths == 8'h50));
  // R5: a seconds carry happens only at 59"99
  p_sec_carry_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    carry[2] |-> (seconds == SEC_LAST_C && hundredths == HUN_LAST_C));
endmodule

// File: tb/sim_stopwatch_timer.sv
`timescale 1ns/1ps
module sim_stopwatch_timer;
  localparam int P = 4;
  localparam int MLAST = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, clear = 1'b0, run1 = 1'b0;
  logic [7:0] minutes, seconds, hundredths, min1, sec1, hun1;
  logic blink, blink1;

  always #10 clk = ~clk;

  stopwatch_timer #(.PRESCALE(P), .MIN_LAST(8'h02)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(clear),
    .minutes(minutes), .seconds(seconds), .hundredths(hundredths), .blink(blink));

  stopwatch_timer u1 (
    .clk(clk), .rst_n(rst_n), .run(run1), .clear(1'b0),
    .minutes(min1), .seconds(sec1), .hundredths(hun1), .blink(blink1));

  int total = 0, bad = 0;
  bit finished = 0;
  int m_pre = 0, m_hun = 0, m_sec = 0, m_min = 0;
  logic [24:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [7:0] to_bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic model_step(logic r, logic c);
    if (c) begin
      m_pre = 0; m_hun = 0; m_sec = 0; m_min = 0;
    end else if (r) begin
      if (m_pre == P - 1) begin
        m_pre = 0;
        m_hun++;
        if (m_hun == 100) begin
          m_hun = 0; m_sec++;
          if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min > MLAST) m_min = 0;
          end
        end
      end else m_pre++;
    end
  endtask

  task automatic drive(int n, logic r, logic c);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      run = r; clear = c;
      @(posedge clk);
      #1 model_step(r, c);
    end
    @(negedge clk);
    run = 1'b0; clear = 1'b0;
    @(posedge clk);
    #1 model_step(1'b0, 1'b0);
  endtask

  task automatic expect_now(string tag);
    exp_q.push_back({to_bcd(m_min), to_bcd(m_sec), to_bcd(m_hun), (m_hun >= 50)});
    tag_q.push_back(tag);
  endtask

  task automatic check(string tag, logic [24:0] act, logic [24:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [24:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {minutes, seconds, hundredths, blink}, e);
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs while still in reset
    check("R1 in reset", {minutes, seconds, hundredths, blink}, 25'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    expect_now("R1 after reset");
    @(negedge clk);

    // R9: default prescale, first increment on the 1000th run cycle
    run1 = 1'b1;
    repeat (999) @(posedge clk);
    #1 check("R9 before 1000", {24'(hun1)}, 24'h00);
    @(posedge clk);
    #1 check("R9 at 1000", {24'(hun1)}, 24'h01);
    @(negedge clk);
    run1 = 1'b0;

    // R3: no increment before P cycles, one at P
    drive(P - 1, 1, 0); expect_now("R3 before tick");
    drive(1, 1, 0);     expect_now("R3 tick");            // 00'00"01
    // R2: pause in the middle of a period keeps value and phase
    drive(2, 1, 0); drive(10, 0, 0); expect_now("R2 hold");
    drive(2, 1, 0);     expect_now("R2 resume");          // 00'00"02
    // R8: blink edge at 50
    drive(47 * P, 1, 0); expect_now("R8 at 49");
    drive(P, 1, 0);      expect_now("R8 at 50");
    // R4: hundredths rollover into seconds
    drive(49 * P, 1, 0); expect_now("R4 at 99");
    drive(P, 1, 0);      expect_now("R4 carry");          // 00'01"00
    // R5: seconds rollover into minutes
    drive((5999 - 100) * P, 1, 0); expect_now("R5 at 59.99");
    drive(P, 1, 0);      expect_now("R5 carry");          // 01'00"00
    // R7: clear on the cycle a tick is due
    drive(P - 1, 1, 0);
    drive(1, 1, 1);      expect_now("R7 clear wins");
    drive(P - 1, 1, 0);  expect_now("R7 phase restarted");
    drive(1, 1, 0);      expect_now("R7 first tick");
    // R6: full wrap after the last minute
    drive((17999 - 1) * P, 1, 0); expect_now("R6 at last");
    drive(P, 1, 0);      expect_now("R6 wrap");           // 00'00"00
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule